// File: doc/BRIEF.md
# Seconds Real-Time Clock with Alarm

This block is a real-time clock that counts whole seconds. It keeps a 32-bit seconds counter and a 32-bit alarm value, and software reaches every part of it through 8-bit registers on a simple synchronous bus. The bus has an address, write data, a write strobe, a read strobe and registered read data. A one-second tick input moves the counter forward by one, but only while the run bit in the control register is set.

Software sets a new time in stages. Bytes 1 to 3 are written into a staging window first. The write to byte 0 then loads all four bytes into the counter in a single cycle. The usual sequence writes 0x00 to byte 0 first, then bytes 1 to 3, then the real byte 0.

The live counter is read back with no snapshot latch. Software detects a carry that happens between byte reads by reading the low byte a second time and seeing a smaller value.

When the counter steps onto the alarm value while the alarm is enabled, a sticky pending flag is set and drives a level interrupt. The flag stays set until software writes the clear bit.

Top module: `sec_rtc`

## Requirements
- R1: After reset, every register, every staged byte, the counter and the alarm value are zero. The interrupt output is low and every readable address returns 0x00.
- R2: The control register at address 0x0 reads back exactly the byte last written to it. Bit 7 is the run bit and bit 1 is the alarm enable.
- R3: While the run bit is 1, each cycle with `tick` high adds one to the counter. While the run bit is 0, ticks leave the counter unchanged.
- R4: Reading addresses 0x6 to 0x9 returns live counter bytes, little-endian: 0x6 holds bits 7:0 and 0x9 holds bits 31:24. Nothing is latched between byte reads, so a carry between two reads of 0x6 shows up as a smaller second value.
- R5: Writes to 0x3, 0x4 and 0x5 store staged bytes 1, 2 and 3 and do not touch the counter. A write to 0x2 loads the counter in that same cycle with {staged byte 3, staged byte 2, staged byte 1, written byte}. Addresses 0x2 to 0x5 read back the staged bytes.
- R6: When a write to 0x2 and a tick fall in the same cycle, the load wins and the tick is lost.
- R7: The counter wraps from 0xFFFFFFFF to 0x00000000 on a tick.
- R8: The alarm value is read and written through addresses 0xA to 0xD, little-endian, with 0xA holding bits 7:0.
- R9: If the counter changes to a value equal to the alarm value while the alarm enable is 1, the pending flag is set one clock later and `alarm_irq` goes high. No flag is set if the alarm enable is 0 when the match begins.
- R10: The pending flag stays set until a 1 is written to bit 0 of address 0x1. Writing 0 to that bit has no effect, and address 0x1 always reads 0x00. If a clear and a new match arrive in the same cycle, the new match wins.
- R11: `bus_rdata` is loaded on the clock edge where `bus_rd` is high and holds its value until the next read. Unmapped addresses 0xE and 0xF read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-second pulse, one cycle wide, synchronous to clk |
| bus_addr | input | 4 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| alarm_irq | output | 1 | Level alarm interrupt (pending flag) |

## Verification
The assertions assume the following about the inputs:
- `tick`, `bus_wr` and `bus_rd` are synchronous to the clock and are never X after reset.
- A write and a read are never issued in the same cycle.
- The counter step check assumes a tick is only counted while no load is happening.

The stimulus stays within these limits. Every bus access is a single strobe raised on a falling clock edge and dropped one cycle later, with reads and writes kept apart. Ticks are driven the same way. Only the priority scenario drives a tick together with a load, which is the case the load-wins rule covers. Alarm matches are produced only by stepping the counter onto the alarm value, both with the enable set and with it cleared.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;

    localparam int BYTE_W = 8;
    localparam int NBYTES = 4;
    localparam int SEC_W  = BYTE_W * NBYTES;
    localparam int ADDR_W = 4;
    localparam int IDX_W  = $clog2(NBYTES);

    // Offsets that software decodes; kept fixed.
    localparam logic [ADDR_W-1:0] OFF_CTRL  = 4'h0;
    localparam logic [ADDR_W-1:0] OFF_ACLR  = 4'h1;
    localparam logic [ADDR_W-1:0] OFF_STAGE = 4'h2;
    localparam logic [ADDR_W-1:0] OFF_LIVE  = 4'h6;
    localparam logic [ADDR_W-1:0] OFF_ALARM = 4'hA;

    localparam int RUN_BIT    = 7;
    localparam int ALM_EN_BIT = 1;
    localparam int ACLR_BIT   = 0;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_ACLR,
        SEL_STAGE,
        SEL_LIVE,
        SEL_ALARM
    } region_e;

    typedef struct packed {
        region_e            region;
        logic [IDX_W-1:0]   idx;
    } reg_sel_t;

    function automatic logic in_window(input logic [ADDR_W-1:0] a,
                                       input logic [ADDR_W-1:0] base);
        logic [ADDR_W-1:0] d;
        d = a - base;
        return (a >= base) && (d < ADDR_W'(NBYTES));
    endfunction

    function automatic logic [IDX_W-1:0] window_idx(input logic [ADDR_W-1:0] a,
                                                    input logic [ADDR_W-1:0] base);
        logic [ADDR_W-1:0] d;
        d = a - base;
        return d[IDX_W-1:0];
    endfunction

    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_t s;
        s.region = SEL_NONE;
        s.idx    = '0;
        if (a == OFF_CTRL) begin
            s.region = SEL_CTRL;
        end else if (a == OFF_ACLR) begin
            s.region = SEL_ACLR;
        end else if (in_window(a, OFF_STAGE)) begin
            s.region = SEL_STAGE;
            s.idx    = window_idx(a, OFF_STAGE);
        end else if (in_window(a, OFF_LIVE)) begin
            s.region = SEL_LIVE;
            s.idx    = window_idx(a, OFF_LIVE);
        end else if (in_window(a, OFF_ALARM)) begin
            s.region = SEL_ALARM;
            s.idx    = window_idx(a, OFF_ALARM);
        end
        return s;
    endfunction

endpackage

// File: rtl/sec_rtc_regfile.sv
module sec_rtc_regfile
    import sec_rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              wr,
    input  logic              rd,
    input  logic [SEC_W-1:0]  live_cnt,
    output logic [BYTE_W-1:0] ctrl_q,
    output logic [SEC_W-1:0]  alarm_val,
    output logic              commit,
    output logic [SEC_W-1:0]  load_val,
    output logic              clr_req,
    output logic [BYTE_W-1:0] rdata
);

    reg_sel_t          sel;
    logic [BYTE_W-1:0] stage_b [NBYTES];
    logic [BYTE_W-1:0] alarm_b [NBYTES];

    assign sel     = decode_addr(addr);
    assign commit  = wr && (sel.region == SEL_STAGE) && (sel.idx == '0);
    assign clr_req = wr && (sel.region == SEL_ACLR) && wdata[ACLR_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr && sel.region == SEL_CTRL) begin
            ctrl_q <= wdata;
        end
    end

    for (genvar i = 0; i < NBYTES; i++) begin : g_bytes
        always_ff @(posedge clk) begin
            if (rst) begin
                stage_b[i] <= '0;
            end else if (wr && sel.region == SEL_STAGE && sel.idx == IDX_W'(i)) begin
                stage_b[i] <= wdata;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                alarm_b[i] <= '0;
            end else if (wr && sel.region == SEL_ALARM && sel.idx == IDX_W'(i)) begin
                alarm_b[i] <= wdata;
            end
        end

        assign alarm_val[i*BYTE_W +: BYTE_W] = alarm_b[i];

        if (i == 0) begin : g_low
            assign load_val[BYTE_W-1:0] = wdata;
        end else begin : g_high
            assign load_val[i*BYTE_W +: BYTE_W] = stage_b[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd) begin
            case (sel.region)
                SEL_CTRL:  rdata <= ctrl_q;
                SEL_STAGE: rdata <= stage_b[sel.idx];
                SEL_LIVE:  rdata <= live_cnt[sel.idx*BYTE_W +: BYTE_W];
                SEL_ALARM: rdata <= alarm_b[sel.idx];
                default:   rdata <= '0;
            endcase
        end
    end

endmodule

// File: rtl/sec_rtc_counter.sv
module sec_rtc_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (run && tick) begin
            cnt <= cnt + W'(1);
        end
    end

endmodule

// File: rtl/sec_rtc_alarm.sv
module sec_rtc_alarm #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] alarm_val,
    input  logic         alarm_en,
    input  logic         clr_req,
    output logic         pending
);

    logic [W-1:0] prev_cnt;
    logic         hit;

    assign hit = alarm_en && (cnt == alarm_val) && (cnt != prev_cnt);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_cnt <= '0;
            pending  <= 1'b0;
        end else begin
            prev_cnt <= cnt;
            if (hit) begin
                pending <= 1'b1;
            end else if (clr_req) begin
                pending <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
    import sec_rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              alarm_irq
);

    logic [BYTE_W-1:0] ctrl_q;
    logic [SEC_W-1:0]  alarm_val;
    logic [SEC_W-1:0]  load_val;
    logic [SEC_W-1:0]  cnt;
    logic              commit;
    logic              clr_req;

    sec_rtc_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .wr        (bus_wr),
        .rd        (bus_rd),
        .live_cnt  (cnt),
        .ctrl_q    (ctrl_q),
        .alarm_val (alarm_val),
        .commit    (commit),
        .load_val  (load_val),
        .clr_req   (clr_req),
        .rdata     (bus_rdata)
    );

    sec_rtc_counter #(.W(SEC_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .run      (ctrl_q[RUN_BIT]),
        .tick     (tick),
        .load     (commit),
        .load_val (load_val),
        .cnt      (cnt)
    );

    sec_rtc_alarm #(.W(SEC_W)) u_alarm (
        .clk       (clk),
        .rst       (rst),
        .cnt       (cnt),
        .alarm_val (alarm_val),
        .alarm_en  (ctrl_q[ALM_EN_BIT]),
        .clr_req   (clr_req),
        .pending   (alarm_irq)
    );

endmodule

// File: rtl/sec_rtc_checker.sv
module sec_rtc_checker
    import sec_rtc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BYTE_W-1:0] bus_wdata,
    input logic [BYTE_W-1:0] ctrl_q,
    input logic [SEC_W-1:0]  cnt,
    input logic              commit,
    input logic [SEC_W-1:0]  load_val,
    input logic              clr_req,
    input logic              irq
);

    a_r2_ctrl_readback: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFF_CTRL) |=> (ctrl_q == $past(bus_wdata)));

    a_r3_hold_when_stopped: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q[RUN_BIT] && !commit) |=> $stable(cnt));

    a_r3_step_on_tick: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q[RUN_BIT] && tick && !commit) |=> (cnt == $past(cnt) + SEC_W'(1)));

    a_r5_commit_loads: assert property (@(posedge clk) disable iff (rst)
        commit |=> (cnt == $past(load_val)));

    a_r9_rise_needs_enable: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(ctrl_q[ALM_EN_BIT]));

    a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
        (irq && !clr_req) |=> irq);

    a_r10_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !ctrl_q[ALM_EN_BIT]) |=> !irq);

endmodule

bind sec_rtc sec_rtc_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .ctrl_q    (ctrl_q),
    .cnt       (cnt),
    .commit    (commit),
    .load_val  (load_val),
    .clr_req   (clr_req),
    .irq       (alarm_irq)
);

// File: tb/sec_rtc_test.sv
module sec_rtc_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic       alarm_irq;

    int checks = 0;
    int fails  = 0;
    logic rd_seen = 1'b0;
    logic done = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } exp_item_t;
    exp_item_t exp_q[$];

    sec_rtc uut (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .alarm_irq (alarm_irq)
    );

    always #10 clk = ~clk;

    always @(posedge clk) rd_seen <= bus_rd;

    // Monitor: compares each read result with the queued expectation
    always @(negedge clk) begin
        if (rd_seen) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL scoreboard: read with no expectation, got %02h", bus_rdata);
            end else begin
                exp_item_t it;
                it = exp_q.pop_front();
                if (bus_rdata !== it.exp) begin
                    fails++;
                    $display("FAIL %s: read data actual %02h expected %02h", it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
        exp_item_t it;
        it.exp = e;
        it.tag = tag;
        exp_q.push_back(it);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic wr_with_tick(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        tick      = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
        tick      = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic chk_bit(input logic act, input logic e, input string tag);
        checks++;
        if (act !== e) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, e);
        end
    endtask

    task automatic chk_byte(input logic [7:0] act, input logic [7:0] e, input string tag);
        checks++;
        if (act !== e) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, e);
        end
    endtask

    task automatic load_time(input logic [31:0] v);
        wr(4'h2, 8'h00);
        wr(4'h3, v[15:8]);
        wr(4'h4, v[23:16]);
        wr(4'h5, v[31:24]);
        wr(4'h2, v[7:0]);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk_bit(alarm_irq, 1'b0, "R1");
        rd(4'h0, 8'h00, "R1");
        rd(4'h6, 8'h00, "R1");
        rd(4'h9, 8'h00, "R1");
        rd(4'hA, 8'h00, "R1");
        rd(4'h3, 8'h00, "R1");

        // R3: counter stopped while run bit is clear
        ticks(3);
        rd(4'h6, 8'h00, "R3");

        // R2: control byte read back in full
        wr(4'h0, 8'hA5);
        rd(4'h0, 8'hA5, "R2");

        // R3: five ticks advance by five
        ticks(5);
        rd(4'h6, 8'h05, "R3");

        // R5: staged load
        wr(4'h2, 8'h00);
        wr(4'h3, 8'h22);
        wr(4'h4, 8'h33);
        wr(4'h5, 8'h44);
        rd(4'h9, 8'h00, "R5");
        rd(4'h4, 8'h33, "R5");
        wr(4'h2, 8'h11);
        rd(4'h2, 8'h11, "R5");
        // R4: little-endian live read
        rd(4'h6, 8'h11, "R4");
        rd(4'h7, 8'h22, "R4");
        rd(4'h8, 8'h33, "R4");
        rd(4'h9, 8'h44, "R4");

        // R6: load wins over tick in the same cycle
        wr_with_tick(4'h2, 8'h50);
        rd(4'h6, 8'h50, "R6");
        rd(4'h9, 8'h44, "R6");

        // R7: wrap
        load_time(32'hFFFF_FFFF);
        rd(4'h9, 8'hFF, "R7");
        ticks(1);
        rd(4'h6, 8'h00, "R7");
        rd(4'h9, 8'h00, "R7");

        // R8: alarm window
        wr(4'hA, 8'h03);
        wr(4'hB, 8'h00);
        wr(4'hC, 8'h00);
        wr(4'hD, 8'h00);
        rd(4'hA, 8'h03, "R8");
        rd(4'hD, 8'h00, "R8");

        // R9: alarm fires one cycle after the match
        wr(4'h0, 8'h82);
        ticks(2);
        chk_bit(alarm_irq, 1'b0, "R9");
        ticks(1);
        chk_bit(alarm_irq, 1'b0, "R9");
        @(negedge clk);
        chk_bit(alarm_irq, 1'b1, "R9");

        // R10: sticky, clear register behaviour
        ticks(2);
        chk_bit(alarm_irq, 1'b1, "R10");
        wr(4'h1, 8'h00);
        @(negedge clk);
        chk_bit(alarm_irq, 1'b1, "R10");
        rd(4'h1, 8'h00, "R10");
        wr(4'h1, 8'h01);
        chk_bit(alarm_irq, 1'b0, "R10");
        rd(4'h1, 8'h00, "R10");

        // R9: no alarm while enable is clear
        wr(4'h0, 8'h80);
        load_time(32'h0000_0002);
        ticks(1);
        rd(4'h6, 8'h03, "R9");
        chk_bit(alarm_irq, 1'b0, "R9");
        @(negedge clk);
        chk_bit(alarm_irq, 1'b0, "R9");

        // R4: carry visible by re-reading the low byte
        load_time(32'h0000_00FF);
        rd(4'h6, 8'hFF, "R4");
        ticks(1);
        rd(4'h6, 8'h00, "R4");
        rd(4'h7, 8'h01, "R4");

        // R11: read data holds, unmapped reads zero
        @(negedge clk);
        @(negedge clk);
        chk_byte(bus_rdata, 8'h01, "R11");
        rd(4'hE, 8'h00, "R11");
        rd(4'hF, 8'h00, "R11");

        @(negedge clk);
        @(negedge clk);
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL scoreboard: %0d reads never returned", exp_q.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule